// File: doc/BRIEF.md
# Regression Quotient and Error-Threshold Unit

This unit is the final stage of a streaming line-fit engine. It receives five signed terms in one strobed cycle: the slope numerator F, the intercept numerator G, the error numerator H, the shared denominator J for slope and intercept, and the error denominator K. It returns the slope b1 = F/J, the intercept b0 = G/J and the mean square error H/K. Each quotient is a two's-complement fixed-point value with `FRAC` fraction bits, truncated toward zero. One sequential restoring divider is time-shared by the three quotients, one quotient bit per cycle. It runs slope first, then intercept, then error. All three results appear together with a single valid pulse.

A second path does not use the divider. It tests whether the error exceeds a programmable threshold T. It does so by cross-multiplying, H·2^FRAC > T·K, and reports the answer one cycle after every input strobe. A zero denominator raises a flag and forces the affected quotients to zero. The quotient latency is the same for every operand set.

The control machine has four states. `ST_IDLE` waits for a strobe. On an accepted strobe it captures the operands and moves to `ST_ISSUE`. `ST_ISSUE` pulses the divider start and always moves to `ST_WAIT`. `ST_WAIT` holds until the divider reports done, then stores the quotient. From there it goes back to `ST_ISSUE` for the next quotient, or to `ST_FLUSH` after the error quotient. `ST_FLUSH` presents the results for one cycle and returns to `ST_IDLE`.

Top module: `lr_regdiv`

## Requirements
- R1: `slope_q` equals trunc(F·2^FRAC / J) as a QW-bit signed value, QW = DW+FRAC+1.
- R2: `icpt_q` equals trunc(G·2^FRAC / J) in the same format.
- R3: `mse_q` equals trunc(H·2^FRAC / K) in the same format.
- R4: `out_valid` is a one-cycle pulse. It rises exactly LAT = 3·(DW+FRAC+2) cycles after the clock edge that accepted `in_valid`, whatever the operand values, including zero denominators.
- R5: J = 0 forces `slope_q` and `icpt_q` to 0. K = 0 forces `mse_q` to 0. `div_zero` is 1 with the results if J or K was zero, and 0 otherwise.
- R6: `in_valid` is accepted only in `ST_IDLE`. A strobe from acceptance through the `out_valid` cycle does not change the quotients of the operation in flight.
- R7: `thr_valid` is high exactly one cycle after each `in_valid` cycle, busy or not. With it, `thr_over` = (H·2^FRAC > T·K), where H and K are signed and T is unsigned with FRAC fraction bits.
- R8: `slope_q`, `icpt_q`, `mse_q` and `div_zero` keep their values between `out_valid` pulses.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| f_num | input | DW | Slope numerator, signed |
| g_num | input | DW | Intercept numerator, signed |
| h_num | input | DW | Error numerator, signed |
| j_den | input | DW | Slope/intercept denominator, signed |
| k_den | input | DW | Error denominator, non-negative |
| thr_lim | input | TW | Error threshold, unsigned, FRAC fraction bits |
| out_valid | output | 1 | Quotients valid pulse |
| slope_q | output | DW+FRAC+1 | Slope quotient |
| icpt_q | output | DW+FRAC+1 | Intercept quotient |
| mse_q | output | DW+FRAC+1 | Error quotient |
| div_zero | output | 1 | A denominator was zero |
| thr_valid | output | 1 | Threshold result valid |
| thr_over | output | 1 | Error exceeds threshold |

## Verification
The bench builds the unit with DW = 12, FRAC = 4 and TW = 10. This gives a 54-cycle quotient latency, so well over a hundred full operations fit in a short run. With 12-bit operands the extreme case is also reachable: F = -2048 over J = -1 gives a quotient of +32768. That value needs the extra sign bit of the 17-bit result. The small widths also make it easy to hit the exact equality H·16 = T·K, where the threshold compare must answer false.

// File: rtl/lr_div_pkg.sv
package lr_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FLUSH = 2'd3
    } lr_state_t;

    typedef enum logic [1:0] {
        SEL_SLOPE = 2'd0,
        SEL_ICPT  = 2'd1,
        SEL_MSE   = 2'd2
    } lr_sel_t;

endpackage

// File: rtl/lr_udiv_core.sv
// Unsigned restoring divider, one quotient bit per cycle.
module lr_udiv_core #(
    parameter int NW = 24,
    parameter int DW = 16,
    localparam int CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dvd,
    input  logic [DW-1:0] dvs,
    output logic          done,
    output logic [NW-1:0] quo
);

    logic [DW-1:0] rem;
    logic [DW-1:0] dvs_r;
    logic [CW-1:0] cnt;
    logic [DW:0]   rem_sh;
    logic [DW+1:0] diff;

    always_comb begin
        rem_sh = {rem, quo[NW-1]};
        diff   = {1'b0, rem_sh} - {2'b00, dvs_r};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            dvs_r <= '0;
            quo   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (start) begin
            rem   <= '0;
            dvs_r <= dvs;
            quo   <= dvd;
            cnt   <= CW'(NW);
            done  <= 1'b0;
        end else if (cnt != '0) begin
            if (!diff[DW+1]) begin
                rem <= diff[DW-1:0];
                quo <= {quo[NW-2:0], 1'b1};
            end else begin
                rem <= rem_sh[DW-1:0];
                quo <= {quo[NW-2:0], 1'b0};
            end
            cnt  <= cnt - 1'b1;
            done <= (cnt == CW'(1));
        end else begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/lr_sdiv.sv
// Signed fixed-point divider built around the unsigned core.
module lr_sdiv #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    localparam int NW  = DW + FRAC,
    localparam int QW  = NW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] num,
    input  logic signed [DW-1:0] den,
    output logic                 done,
    output logic signed [QW-1:0] quot
);

    logic [DW-1:0] num_mag;
    logic [DW-1:0] den_mag;
    logic [NW-1:0] dvd;
    logic [NW-1:0] mag_q;
    logic          neg_r;

    always_comb begin
        num_mag = num[DW-1] ? (~num + 1'b1) : num;
        den_mag = den[DW-1] ? (~den + 1'b1) : den;
    end

    generate
        if (FRAC > 0) begin : g_shift
            assign dvd = {num_mag, {FRAC{1'b0}}};
        end else begin : g_noshift
            assign dvd = num_mag;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_r <= 1'b0;
        end else if (start) begin
            neg_r <= num[DW-1] ^ den[DW-1];
        end
    end

    lr_udiv_core #(.NW(NW), .DW(DW)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .dvd   (dvd),
        .dvs   (den_mag),
        .done  (done),
        .quo   (mag_q)
    );

    always_comb begin
        if (neg_r) quot = -$signed({1'b0, mag_q});
        else       quot =  $signed({1'b0, mag_q});
    end

endmodule

// File: rtl/lr_thr_cmp.sv
// Cross-multiplied error threshold test: H*2^FRAC > T*K.
module lr_thr_cmp #(
    parameter int DW   = 16,
    parameter int TW   = 12,
    parameter int FRAC = 8,
    localparam int CW  = DW + TW + FRAC + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] h_num,
    input  logic signed [DW-1:0] k_den,
    input  logic [TW-1:0]        thr_lim,
    output logic                 thr_valid,
    output logic                 thr_over
);

    logic signed [CW-1:0] lhs;
    logic signed [CW-1:0] t_ext;
    logic signed [CW-1:0] k_ext;
    logic signed [CW-1:0] rhs;

    always_comb begin
        lhs   = $signed({{(CW-DW){h_num[DW-1]}}, h_num}) <<< FRAC;
        t_ext = $signed({{(CW-TW){1'b0}}, thr_lim});
        k_ext = $signed({{(CW-DW){k_den[DW-1]}}, k_den});
        rhs   = t_ext * k_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_valid <= 1'b0;
            thr_over  <= 1'b0;
        end else begin
            thr_valid <= in_valid;
            if (in_valid) thr_over <= (lhs > rhs);
        end
    end

endmodule

// File: rtl/lr_regdiv.sv
module lr_regdiv
    import lr_div_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int TW   = 12,
    localparam int NW  = DW + FRAC,
    localparam int QW  = NW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] f_num,
    input  logic signed [DW-1:0] g_num,
    input  logic signed [DW-1:0] h_num,
    input  logic signed [DW-1:0] j_den,
    input  logic signed [DW-1:0] k_den,
    input  logic [TW-1:0]        thr_lim,
    output logic                 out_valid,
    output logic signed [QW-1:0] slope_q,
    output logic signed [QW-1:0] icpt_q,
    output logic signed [QW-1:0] mse_q,
    output logic                 div_zero,
    output logic                 thr_valid,
    output logic                 thr_over
);

    lr_state_t st, st_nx;
    lr_sel_t   sel;

    logic signed [DW-1:0] f_r, g_r, h_r, j_r, k_r;
    logic signed [DW-1:0] num_sel, den_sel;
    logic signed [QW-1:0] slot_s, slot_i;
    logic signed [QW-1:0] div_quot, res;
    logic                 div_start, div_done;
    logic                 accept, store, den_zero, dz_acc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (in_valid) st_nx = ST_ISSUE;
            ST_ISSUE: st_nx = ST_WAIT;
            ST_WAIT:  if (div_done) st_nx = (sel == SEL_MSE) ? ST_FLUSH : ST_ISSUE;
            ST_FLUSH: st_nx = ST_IDLE;
        endcase
    end

    // state-decoded controls
    always_comb begin
        div_start = (st == ST_ISSUE);
        out_valid = (st == ST_FLUSH);
        accept    = (st == ST_IDLE) && in_valid;
        store     = (st == ST_WAIT) && div_done;
    end

    // operand selection for the shared divider
    always_comb begin
        unique case (sel)
            SEL_ICPT: begin num_sel = g_r; den_sel = j_r; end
            SEL_MSE:  begin num_sel = h_r; den_sel = k_r; end
            default:  begin num_sel = f_r; den_sel = j_r; end
        endcase
        den_zero = (den_sel == '0);
        res      = den_zero ? '0 : div_quot;
    end

    lr_sdiv #(.DW(DW), .FRAC(FRAC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (num_sel),
        .den   (den_sel),
        .done  (div_done),
        .quot  (div_quot)
    );

    // operand capture, quotient slots and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_r      <= '0;
            g_r      <= '0;
            h_r      <= '0;
            j_r      <= '0;
            k_r      <= '0;
            sel      <= SEL_SLOPE;
            dz_acc   <= 1'b0;
            slot_s   <= '0;
            slot_i   <= '0;
            slope_q  <= '0;
            icpt_q   <= '0;
            mse_q    <= '0;
            div_zero <= 1'b0;
        end else if (accept) begin
            f_r    <= f_num;
            g_r    <= g_num;
            h_r    <= h_num;
            j_r    <= j_den;
            k_r    <= k_den;
            sel    <= SEL_SLOPE;
            dz_acc <= 1'b0;
        end else if (store) begin
            dz_acc <= dz_acc | den_zero;
            unique case (sel)
                SEL_SLOPE: begin
                    slot_s <= res;
                    sel    <= SEL_ICPT;
                end
                SEL_ICPT: begin
                    slot_i <= res;
                    sel    <= SEL_MSE;
                end
                default: begin
                    slope_q  <= slot_s;
                    icpt_q   <= slot_i;
                    mse_q    <= res;
                    div_zero <= dz_acc | den_zero;
                    sel      <= SEL_SLOPE;
                end
            endcase
        end
    end

    lr_thr_cmp #(.DW(DW), .TW(TW), .FRAC(FRAC)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .h_num     (h_num),
        .k_den     (k_den),
        .thr_lim   (thr_lim),
        .thr_valid (thr_valid),
        .thr_over  (thr_over)
    );

endmodule

// File: rtl/lr_regdiv_chk.sv
module lr_regdiv_chk #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    localparam int QW  = DW + FRAC + 1,
    localparam int LAT = 3 * (DW + FRAC + 2),
    localparam int LW  = $clog2(LAT + 2) + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [QW-1:0] slope_q,
    input logic signed [QW-1:0] icpt_q,
    input logic signed [QW-1:0] mse_q,
    input logic                 div_zero,
    input logic                 thr_valid
);

    logic          busy;
    logic [LW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy <= 1'b1;
                cnt  <= LW'(1);
            end
        end else if (out_valid) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy && cnt == LW'(LAT + 1)));

    assert_thr_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> thr_valid);

    assert_thr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !thr_valid);

    assert_zero_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && div_zero) |-> ((slope_q == '0 && icpt_q == '0) || mse_q == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(slope_q) && $stable(icpt_q) && $stable(mse_q) && $stable(div_zero)));

endmodule

bind lr_regdiv lr_regdiv_chk #(.DW(DW), .FRAC(FRAC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .slope_q   (slope_q),
    .icpt_q    (icpt_q),
    .mse_q     (mse_q),
    .div_zero  (div_zero),
    .thr_valid (thr_valid)
);

// File: tb/sim_lr_regdiv.sv
`timescale 1ns/1ps
module sim_lr_regdiv;

    localparam int DW   = 12;
    localparam int FRAC = 4;
    localparam int TW   = 10;
    localparam int QW   = DW + FRAC + 1;
    localparam int LAT  = 3 * (DW + FRAC + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] f_s = '0, g_s = '0, h_s = '0, j_s = '0, k_s = '0;
    logic [TW-1:0] t_s = '0;
    logic out_valid, div_zero, thr_valid, thr_over;
    logic signed [QW-1:0] slope_q, icpt_q, mse_q;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lr_regdiv #(.DW(DW), .FRAC(FRAC), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .f_num(f_s), .g_num(g_s), .h_num(h_s), .j_den(j_s), .k_den(k_s),
        .thr_lim(t_s), .out_valid(out_valid), .slope_q(slope_q),
        .icpt_q(icpt_q), .mse_q(mse_q), .div_zero(div_zero),
        .thr_valid(thr_valid), .thr_over(thr_over)
    );

    function automatic longint exp_q(longint num, longint den);
        if (den == 0) return 0;
        return (num * (64'sd1 <<< FRAC)) / den;
    endfunction

    function automatic bit exp_over(longint h, longint t, longint k);
        return (h * (64'sd1 <<< FRAC)) > (t * k);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input longint f, g, h, j, k, t, input bit inject);
        longint ef, eg, eh, ej, ek;
        @(negedge clk);
        f_s = f[DW-1:0]; g_s = g[DW-1:0]; h_s = h[DW-1:0];
        j_s = j[DW-1:0]; k_s = k[DW-1:0]; t_s = t[TW-1:0];
        ef = f_s; eg = g_s; eh = h_s; ej = j_s; ek = k_s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 thr_valid", thr_valid, 1);
        chk("R7 thr_over", thr_over, exp_over(eh, longint'(t_s), ek));
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            if (inject && i == 10) begin
                f_s = f_s + 12'sd77; g_s = -g_s; h_s = h_s + 12'sd5;
                j_s = 12'sd3; k_s = 12'sd1; t_s = '0;
                in_valid = 1'b1;
            end else if (inject && i == 11) begin
                in_valid = 1'b0;
                chk("R7 busy thr_valid", thr_valid, 1);
                chk("R7 busy thr_over", thr_over, exp_over(longint'(h_s), 0, 1));
            end
        end
        chk("R4 not early", out_valid, 0);
        @(negedge clk);
        chk("R4 out_valid at LAT", out_valid, 1);
        chk(inject ? "R6 R1 slope" : "R1 slope", slope_q, exp_q(ef, ej));
        chk(inject ? "R6 R2 icpt" : "R2 icpt", icpt_q, exp_q(eg, ej));
        chk(inject ? "R6 R3 mse" : "R3 mse", mse_q, exp_q(eh, ek));
        chk("R5 div_zero", div_zero, (ej == 0 || ek == 0) ? 1 : 0);
        @(negedge clk);
        chk("R4 pulse width", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", out_valid, 0);
        chk("R9 thr_valid", thr_valid, 0);
        chk("R9 thr_over", thr_over, 0);
        chk("R9 slope", slope_q, 0);
        chk("R9 icpt", icpt_q, 0);
        chk("R9 mse", mse_q, 0);
        chk("R9 div_zero", div_zero, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case(100, -37, 500, 7, 9, 200, 0);
        run_case(-640, 1000, 2047, -13, 2047, 1023, 0);
        run_case(55, 66, 77, 0, 5, 10, 0);        // R5 J zero
        run_case(55, -66, 77, 4, 0, 10, 0);       // R5 K zero
        run_case(1, 2, 3, 0, 0, 0, 0);            // R5 both zero
        run_case(-2048, -2048, -2048, -1, 1, 0, 0); // extreme quotient
        run_case(0, 0, 0, -5, 3, 0, 0);
        run_case(30, 1, 30, 2, 10, 48, 0);        // R7 equality: not over
        run_case(30, 1, 30, 2, 10, 47, 0);        // R7 just over
        run_case(-30, 1, -30, 2, 10, 0, 0);       // R7 negative H
        run_case(321, -123, 999, 17, 41, 300, 1); // R6 strobe while busy

        // R8 hold between pulses
        begin
            longint hs, hi, hm, hz;
            hs = slope_q; hi = icpt_q; hm = mse_q; hz = div_zero;
            repeat (6) @(negedge clk);
            chk("R8 slope hold", slope_q, hs);
            chk("R8 icpt hold", icpt_q, hi);
            chk("R8 mse hold", mse_q, hm);
            chk("R8 div_zero hold", div_zero, hz);
        end

        for (int n = 0; n < 120; n++) begin
            longint rj, rk;
            rj = ($urandom_range(0, 7) == 0) ? 0 : longint'($urandom);
            rk = ($urandom_range(0, 9) == 0) ? 0 : longint'($urandom_range(0, 2047));
            run_case(longint'($urandom), longint'($urandom), longint'($urandom),
                     rj, rk, longint'($urandom), (n % 9) == 4);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule